// File: doc/BRIEF.md
# Lockable GPIO Port with Pad Model

This block is a 32-pin general-purpose I/O port that software controls through a plain word-wide register interface. Each pin is configured by several registers: an output value, a driver enable, a driver type (push-pull or open-drain), a polarity inversion, a weak pull-up, a weak pull-down and an input gate. The output value and the driver enable also have write-one-to-set and write-one-to-clear aliases. These let software change single pins without a read-modify-write.

The block does not drive real pads. It computes a model of each pad from the active driver and the weak pulls, and it exposes that level on `pin_level`. The readable input register is derived from the same level, so a program can see what its own settings would produce on the pin.

A write lock protects the configuration. Any write to either lock register locks the port. To open it again, software writes a fixed key to the second lock register and then a second fixed key to the first one.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, the output value, driver enable, driver type, polarity and pull-down registers read 0. The pull-up and input-gate registers read all ones. The lock reads 0 (open), and the input register reads all ones.
- R2: Registers sit at these byte offsets. Lock-A is at 0x00. The input value (read-only) is at 0x04, polarity at 0x08 and output value at 0x0C. Driver enable is at 0x10 and driver type at 0x14. Pull-up is at 0x1C, pull-down at 0x20 and input gate at 0x58. Output-value set is at 0x68 and output-value clear at 0x6C. Driver-enable set is at 0x70 and driver-enable clear at 0x74. Lock-B is at 0x7C. A plain register reads back what was last written to it.
- R3: A pin with its driver enabled and driver type 0 (push-pull) takes the level (output value XOR polarity). Its pulls have no effect.
- R4: A pin with its driver enabled and driver type 1 (open-drain) is forced low when (output value XOR polarity) is 0. When it is 1, the pin is released to its pulls.
- R5: A pin with its driver disabled takes its level from the pulls: high only when pull-up is 1 and pull-down is 0. Equal pulls give low. Driver type has no effect on such a pin.
- R6: Each bit of the input register equals the pin level AND the input gate, XOR polarity. A pin with polarity 1 in push-pull mode therefore reads back its own output value.
- R7: A pin whose input gate is 0 reads as its polarity bit.
- R8: A write to a set alias ORs the written mask into its target. A write to a clear alias clears the masked bits of its target. For example, clearing 0x00030002 from 0x3456789A gives 0x34547898.
- R9: Lock-A reads 1 while locked and 0 while open. Writing any value to Lock-A or Lock-B while open locks the port.
- R10: While the port is locked, writes to every configuration register and to all four aliases leave their contents unchanged.
- R11: While locked, writing 0xC0DE1248 to Lock-B and then 0xC0DEFA73 to Lock-A opens the port.
- R12: While locked, each of the following leaves the port locked and cancels any armed state. Writing 0xC0DEFA73 to Lock-A without a preceding armed key. Writing a wrong value to Lock-B. Writing a wrong value to Lock-A after the arming key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 7 | Byte offset of the register (word aligned) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_level | output | NPINS (32) | Modelled level of each pad |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are known, 2-state values on every rising edge after reset. They also assume that a write's data belongs to that single cycle, because the alias checks compare the new register value with the mask sampled one cycle earlier. The bench meets these assumptions as follows. It changes inputs only on falling edges. It holds `wr_en` high for exactly one cycle per write. It uses only the word-aligned offsets listed in R2, so no strobe ever meets an undefined address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 7;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_LOCK_A   = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_DIN      = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_POL      = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_DOUT     = 7'h0C;
    localparam logic [ADDR_W-1:0] OFF_OE       = 7'h10;
    localparam logic [ADDR_W-1:0] OFF_OTYPE    = 7'h14;
    localparam logic [ADDR_W-1:0] OFF_PU       = 7'h1C;
    localparam logic [ADDR_W-1:0] OFF_PD       = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_IGATE    = 7'h58;
    localparam logic [ADDR_W-1:0] OFF_DOUT_SET = 7'h68;
    localparam logic [ADDR_W-1:0] OFF_DOUT_CLR = 7'h6C;
    localparam logic [ADDR_W-1:0] OFF_OE_SET   = 7'h70;
    localparam logic [ADDR_W-1:0] OFF_OE_CLR   = 7'h74;
    localparam logic [ADDR_W-1:0] OFF_LOCK_B   = 7'h7C;

    localparam logic [BUS_W-1:0] KEY_ARM  = 32'hC0DE_1248;
    localparam logic [BUS_W-1:0] KEY_OPEN = 32'hC0DE_FA73;

    typedef enum logic [1:0] {
        LK_OPEN  = 2'd0,
        LK_SHUT  = 2'd1,
        LK_ARMED = 2'd2
    } lock_st_e;

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic                locked
);

    typedef struct packed {
        lock_st_e st;
    } lock_state_t;

    lock_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (addr == OFF_LOCK_B) begin
                if (s_q.st == LK_OPEN)       s_d.st = LK_SHUT;
                else if (wdata == KEY_ARM)   s_d.st = LK_ARMED;
                else                         s_d.st = LK_SHUT;
            end else if (addr == OFF_LOCK_A) begin
                if (s_q.st == LK_ARMED && wdata == KEY_OPEN) s_d.st = LK_OPEN;
                else                                         s_d.st = LK_SHUT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: LK_OPEN};
        else        s_q <= s_d;
    end

    assign locked = (s_q.st != LK_OPEN);

    a_r9_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked && (addr == OFF_LOCK_A || addr == OFF_LOCK_B)) |=> locked);

    a_r11_key_pair_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.st == LK_ARMED && addr == OFF_LOCK_A && wdata == KEY_OPEN) |=> !locked);

    a_r12_bad_arm_key_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked && addr == OFF_LOCK_B && wdata != KEY_ARM) |=> (s_q.st == LK_SHUT));

    a_r12_unarmed_open_key_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.st == LK_SHUT && addr == OFF_LOCK_A) |=> (s_q.st == LK_SHUT));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                cfg_open,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NPINS-1:0]    wdata,
    output logic [NPINS-1:0]    dout,
    output logic [NPINS-1:0]    oe,
    output logic [NPINS-1:0]    otype,
    output logic [NPINS-1:0]    pol,
    output logic [NPINS-1:0]    pu,
    output logic [NPINS-1:0]    pd,
    output logic [NPINS-1:0]    igate
);

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] otype;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] pu;
        logic [NPINS-1:0] pd;
        logic [NPINS-1:0] igate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        dout: '0, oe: '0, otype: '0, pol: '0,
        pu: '1, pd: '0, igate: '1
    };

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en && cfg_open) begin
            case (addr)
                OFF_DOUT:     c_d.dout  = wdata;
                OFF_OE:       c_d.oe    = wdata;
                OFF_OTYPE:    c_d.otype = wdata;
                OFF_POL:      c_d.pol   = wdata;
                OFF_PU:       c_d.pu    = wdata;
                OFF_PD:       c_d.pd    = wdata;
                OFF_IGATE:    c_d.igate = wdata;
                OFF_DOUT_SET: c_d.dout  = c_q.dout | wdata;
                OFF_DOUT_CLR: c_d.dout  = c_q.dout & ~wdata;
                OFF_OE_SET:   c_d.oe    = c_q.oe | wdata;
                OFF_OE_CLR:   c_d.oe    = c_q.oe & ~wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CFG_RESET;
        else        c_q <= c_d;
    end

    assign dout  = c_q.dout;
    assign oe    = c_q.oe;
    assign otype = c_q.otype;
    assign pol   = c_q.pol;
    assign pu    = c_q.pu;
    assign pd    = c_q.pd;
    assign igate = c_q.igate;

    a_r10_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_open) |=> $stable(c_q));

    a_r8_oe_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_open && addr == OFF_OE_SET) |=> ((c_q.oe & $past(wdata)) == $past(wdata)));

    a_r8_dout_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_open && addr == OFF_DOUT_CLR) |=> ((c_q.dout & $past(wdata)) == '0));

    a_r8_oe_clear_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_open && addr == OFF_OE_CLR)
            |=> ((c_q.oe ^ $past(c_q.oe)) & ~$past(wdata)) == '0);

endmodule

// File: rtl/gpio_pad_model.sv
module gpio_pad_model #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] otype,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] pu,
    input  logic [NPINS-1:0] pd,
    input  logic [NPINS-1:0] igate,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] din
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pad
        logic drive_b;
        logic pulled_b;
        logic driven_b;

        assign drive_b  = dout[g] ^ pol[g];
        assign pulled_b = pu[g] & ~pd[g];
        // open-drain passes a 1 only as a release to the pulls
        assign driven_b = otype[g] ? (drive_b & pulled_b) : drive_b;
        assign level[g] = oe[g] ? driven_b : pulled_b;
        assign din[g]   = (level[g] & igate[g]) ^ pol[g];
    end

endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    output logic [NPINS-1:0]    pin_level
);

    logic               locked;
    logic [NPINS-1:0]   dout, oe, otype, pol, pu, pd, igate, din;

    gpio_lock_ctrl u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .locked (locked)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cfg_open (!locked),
        .addr     (addr),
        .wdata    (wdata[NPINS-1:0]),
        .dout     (dout),
        .oe       (oe),
        .otype    (otype),
        .pol      (pol),
        .pu       (pu),
        .pd       (pd),
        .igate    (igate)
    );

    gpio_pad_model #(.NPINS(NPINS)) u_pads (
        .dout   (dout),
        .oe     (oe),
        .otype  (otype),
        .pol    (pol),
        .pu     (pu),
        .pd     (pd),
        .igate  (igate),
        .level  (pin_level),
        .din    (din)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LOCK_A: rdata = BUS_W'(locked);
            OFF_DIN:    rdata = BUS_W'(din);
            OFF_POL:    rdata = BUS_W'(pol);
            OFF_DOUT:   rdata = BUS_W'(dout);
            OFF_OE:     rdata = BUS_W'(oe);
            OFF_OTYPE:  rdata = BUS_W'(otype);
            OFF_PU:     rdata = BUS_W'(pu);
            OFF_PD:     rdata = BUS_W'(pd);
            OFF_IGATE:  rdata = BUS_W'(igate);
            default:    rdata = '0;
        endcase
    end

    a_r3_push_pull_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level ^ dout ^ pol) & oe & ~otype) == '0);

    a_r4_open_drain_sinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & oe & otype & ~(dout ^ pol)) == '0);

    a_r5_undriven_equal_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & ~oe & ~(pu ^ pd)) == '0);

    a_r7_gated_reads_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        ((din ^ pol) & ~igate) == '0);

endmodule

// File: tb/gpio_lock_port_tb.sv
`timescale 1ns/1ps
module gpio_lock_port_tb;
    import gpio_port_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [31:0]       pin_level;

    int checks = 0;
    int failures = 0;
    logic [31:0] saved;

    always #4 clk = ~clk;

    gpio_lock_port #(.NPINS(32)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .pin_level (pin_level)
    );

    typedef struct packed {
        logic [31:0] pol, otype, oe, dout, pu, pd, igate, exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R3: push-pull follows output value, pulls ignored
        '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h12345678, 32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 32'h12345678, 8'd3},
        // R5: undriven, pulls complementary
        '{32'h0, 32'h0, 32'h0, 32'hFFFF0000, 32'h23456789, 32'hDCBA9876, 32'hFFFFFFFF, 32'h23456789, 8'd5},
        // R3: enable pattern visible against pull-down
        '{32'h0, 32'h0, 32'h3456789A, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h3456789A, 8'd3},
        // R4: open-drain mix
        '{32'h0, 32'h456789AB, 32'hF0F0F0F0, 32'hFFFF0000, 32'hFF00FF00, 32'h00FF00FF, 32'hFFFFFFFF, 32'hFF900F00, 8'd4},
        // R6: inversion both ways in push-pull
        '{32'h6789ABCD, 32'h0, 32'hFFFFFFFF, 32'h56789ABC, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h56789ABC, 8'd6},
        // R6: undriven with inversion
        '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h789ABCDE, 32'h87654321, 32'hFFFFFFFF, 32'h87654321, 8'd6},
        // R6: open-drain with inversion
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFF00FF00, 32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFF00FFFF, 8'd6},
        // R7: gate applied before inversion
        '{32'hFFFF0000, 32'h0, 32'hFFFFFFFF, 32'hFF00FF00, 32'hFFFFFFFF, 32'h0, 32'h87654321, 32'hFF9A4300, 8'd7},
        // R5: equal pulls read low, driver type ignored
        '{32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000FFFF, 32'h0000FF00, 32'hFFFFFFFF, 32'h000000FF, 8'd5},
        // R4: released open-drain with equal pulls reads low
        '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 8'd4}
    };

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] got;
        rd(a, got);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s offset=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", OFF_DOUT,  32'h0);
        chk("R1", OFF_OE,    32'h0);
        chk("R1", OFF_POL,   32'h0);
        chk("R1", OFF_PD,    32'h0);
        chk("R1", OFF_PU,    32'hFFFFFFFF);
        chk("R1", OFF_IGATE, 32'hFFFFFFFF);
        chk("R1", OFF_LOCK_A, 32'h0);
        chk("R1", OFF_DIN,   32'hFFFFFFFF);

        // pin model vectors
        for (int i = 0; i < NV; i++) begin
            wr(OFF_POL,   VECS[i].pol);
            wr(OFF_OTYPE, VECS[i].otype);
            wr(OFF_OE,    VECS[i].oe);
            wr(OFF_DOUT,  VECS[i].dout);
            wr(OFF_PU,    VECS[i].pu);
            wr(OFF_PD,    VECS[i].pd);
            wr(OFF_IGATE, VECS[i].igate);
            chk($sformatf("R%0d", VECS[i].req), OFF_DIN, VECS[i].exp);
        end

        // R2: readback at each offset
        wr(OFF_POL, 32'h13572468);   chk("R2", OFF_POL, 32'h13572468);
        wr(OFF_OTYPE, 32'h0F0F1234); chk("R2", OFF_OTYPE, 32'h0F0F1234);
        wr(OFF_PD, 32'hA5A5A5A5);    chk("R2", OFF_PD, 32'hA5A5A5A5);
        wr(OFF_IGATE, 32'h5A5A0001); chk("R2", OFF_IGATE, 32'h5A5A0001);

        // R8: aliases
        wr(OFF_OE, 32'h3456789A);
        wr(OFF_OE_CLR, 32'h00030002); chk("R8", OFF_OE, 32'h34547898);
        wr(OFF_OE_SET, 32'h0000F001); chk("R8", OFF_OE, 32'h3454F899);
        wr(OFF_DOUT, 32'h0);
        wr(OFF_DOUT_SET, 32'h00008200); chk("R8", OFF_DOUT, 32'h00008200);
        wr(OFF_DOUT_CLR, 32'h00008000); chk("R8", OFF_DOUT, 32'h00000200);

        // R9: lock via Lock-A
        chk("R9", OFF_LOCK_A, 32'h0);
        rd(OFF_PU, saved);
        wr(OFF_LOCK_A, 32'h0);
        chk("R9", OFF_LOCK_A, 32'h1);

        // R10: locked writes ignored
        wr(OFF_DOUT, 32'hA9876543);     chk("R10", OFF_DOUT, 32'h00000200);
        wr(OFF_DOUT_SET, 32'hFFFFFFFF); chk("R10", OFF_DOUT, 32'h00000200);
        wr(OFF_OE_CLR, 32'hFFFFFFFF);   chk("R10", OFF_OE, 32'h3454F899);
        wr(OFF_PU, ~saved);             chk("R10", OFF_PU, saved);

        // R11: correct key pair
        wr(OFF_LOCK_B, KEY_ARM);
        wr(OFF_LOCK_A, KEY_OPEN);
        chk("R11", OFF_LOCK_A, 32'h0);
        wr(OFF_DOUT, 32'hA9876543); chk("R11", OFF_DOUT, 32'hA9876543);

        // R9: lock via Lock-B
        wr(OFF_LOCK_B, 32'h0);
        chk("R9", OFF_LOCK_A, 32'h1);

        // R12: wrong orders and keys
        wr(OFF_LOCK_A, KEY_OPEN);
        chk("R12", OFF_LOCK_A, 32'h1);
        wr(OFF_LOCK_B, KEY_ARM);
        wr(OFF_LOCK_B, 32'h1);
        wr(OFF_LOCK_A, KEY_OPEN);
        chk("R12", OFF_LOCK_A, 32'h1);
        wr(OFF_LOCK_B, KEY_ARM);
        wr(OFF_LOCK_A, 32'h0);
        wr(OFF_LOCK_A, KEY_OPEN);
        chk("R12", OFF_LOCK_A, 32'h1);

        // R11: recovery after failed attempts
        wr(OFF_LOCK_B, KEY_ARM);
        wr(OFF_LOCK_A, KEY_OPEN);
        chk("R11", OFF_LOCK_A, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule